// File: doc/BRIEF.md
# Burst Copy Sequencer from 16-bit SDRAM to 32-bit Local RAM

This block is a timing-exact copy engine. Once started, it moves a given number of bytes out of an external SDRAM that has a 16-bit data path. The bytes go into an on-chip RAM whose 32-bit write port completes in a single cycle. The SDRAM side is a simplified command bus with these commands: row activate, read, burst terminate, precharge and auto refresh. The read data is treated as valid in the same cycle its address is presented. Each destination word is assembled from two consecutive halfword beats of one open full-page burst. The engine charges fixed state costs for each phase:

- opening the burst costs 5 states;
- each word costs 3 states (two beats and one write);
- closing the burst costs 2 states;
- each refresh serviced in the middle of the copy costs 7 states.

The total elapsed time is therefore exact. A 512-byte copy with no refresh takes 391 states.

A refresh request is raised periodically and is counted in busy cycles from the start. It is serviced between two words. The engine finishes the word in hand, precharges, refreshes, reopens the row and resumes at the next column. The block reports busy, a done pulse, an error flag for illegal lengths, and a cycle counter of the elapsed busy states. That counter lets measured time be compared with the computed cost.

The states are named as follows:

- ST_IDLE waits for start.
- ST_OPEN covers the burst opening (5 states).
- ST_BEAT_LO and ST_BEAT_HI capture the two halfwords.
- ST_WRITE stores the word.
- ST_PRECH (2 states) and ST_REFRESH (5 states) service a refresh.
- ST_CLOSE (2 states) ends the burst.

The transitions are:

| From | To | Condition |
|---|---|---|
| ST_IDLE | ST_OPEN | On an accepted start |
| ST_OPEN | ST_BEAT_LO | After the opening states |
| ST_BEAT_LO | ST_BEAT_HI | Always |
| ST_BEAT_HI | ST_WRITE | Always |
| ST_WRITE | ST_CLOSE | If it was the last word |
| ST_WRITE | ST_PRECH | Otherwise, if a refresh is pending |
| ST_WRITE | ST_BEAT_LO | Otherwise |
| ST_PRECH | ST_REFRESH | After the precharge states |
| ST_REFRESH | ST_BEAT_LO | After the refresh states |
| ST_CLOSE | ST_IDLE | After the closing states |

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, busy, done, err and ram_we are low, sd_cmd is NOP (0) and elapsed is 0; sd_cmd stays NOP whenever busy is low.
- R2: A start seen while idle with a byte_count that is zero or not a multiple of 4 sets err in the next cycle and leaves busy low and elapsed unchanged; an accepted start clears err.
- R3: An accepted start makes busy high in the next cycle, with 5 opening states: ACT (1) in the first, READ (2) in the third, NOP (0) otherwise.
- R4: Each word takes exactly 3 states: a low beat, a high beat, then one state with ram_we high. The first halfword goes to ram_wdata[15:0] and the second to ram_wdata[31:16]. ram_we is never high in two consecutive cycles.
- R5: For word k, sd_addr is src+4k in the low beat and src+4k+2 in the high beat, and ram_addr is dst+4k during the write.
- R6: After the last write, the burst closes in 2 states, BST (3) then PRE (4). busy is then low and done is high for exactly one cycle.
- R7: A refresh becomes pending after every REF_INTERVAL busy cycles counted from the start. It is taken after a write when further words remain, as 7 states of commands PRE, NOP, REF (5), NOP, NOP, ACT, READ, with sd_addr showing the next word's source during the last one.
- R8: A refresh pending when the last word is written is not serviced. The pending state and the interval count restart on every accepted start.
- R9: elapsed is cleared by an accepted start, increases by one per busy cycle and holds while idle. At done it equals 7 + 3*words + 7*refreshes.
- R10: start and byte_count are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a copy (honoured only when idle) |
| byte_count | input | CNT_W | Copy length in bytes |
| src_addr | input | AW | SDRAM byte address of the first halfword |
| dst_addr | input | AW | Local RAM byte address of the first word |
| sd_cmd | output | 3 | SDRAM command: 0 NOP, 1 ACT, 2 READ, 3 BST, 4 PRE, 5 REF |
| sd_addr | output | AW | SDRAM byte address of the current beat |
| sd_rdata | input | 16 | SDRAM read data for sd_addr |
| ram_we | output | 1 | Local RAM write strobe |
| ram_addr | output | AW | Local RAM byte address |
| ram_wdata | output | 32 | Packed word to write |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected for its length |
| elapsed | output | ELAPSED_W | Busy states since the last accepted start |

## Verification
Every output is due one cycle after the edge that samples a stimulus. A start applied before an edge shows busy, the first ACT and elapsed equal to 0 in the very next cycle, and each later busy cycle k carries the command, addresses and elapsed value k-1 that the bench's reference trace predicts for that cycle. The bench builds the expected per-cycle trace as a queue when it applies start, placing refreshes by counting busy cycles against the interval. It then compares every output once per cycle on the falling edge, until the trace is exhausted. In the cycle after the trace ends it expects done, low busy and the total cost, and one cycle later it expects done low and elapsed frozen. Copy lengths of 310, 311 and 312 words place the first refresh just after, exactly at and just before the final write.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int OPEN_CYC  = 5;
    localparam int RCD_CYC   = 2;
    localparam int CLOSE_CYC = 2;
    localparam int PRE_CYC   = 2;
    localparam int REF_CYC   = 5;
    localparam int PH_W      = 3;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_READ = 3'd2,
        CMD_BST  = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_BEAT_LO,
        ST_BEAT_HI,
        ST_WRITE,
        ST_PRECH,
        ST_REFRESH,
        ST_CLOSE
    } seq_state_e;

endpackage

// File: rtl/dma_refresh_timer.sv
module dma_refresh_timer #(
    parameter int INTERVAL = 936
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic service,
    output logic pending
);
    localparam int TW = $clog2(INTERVAL + 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] tick_q;
    logic          pend_q;
    logic          fire;

    assign fire    = run && (tick_q == LAST);
    assign pending = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            pend_q <= 1'b0;
        end else if (restart) begin
            tick_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (run) begin
                tick_q <= fire ? '0 : tick_q + 1'b1;
            end
            if (fire) begin
                pend_q <= 1'b1;
            end else if (service) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    src_in,
    input  logic [AW-1:0]    dst_in,
    input  logic [CNT_W-1:0] words_in,
    input  logic             advance,
    input  logic             hi_beat,
    output logic [AW-1:0]    sd_addr,
    output logic [AW-1:0]    ram_addr,
    output logic             last_word
);
    localparam logic [AW-1:0] WORD_STEP = AW'(4);
    localparam logic [AW-1:0] HALF_STEP = AW'(2);

    logic [AW-1:0]    src_q;
    logic [AW-1:0]    dst_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
        end else if (load) begin
            src_q  <= src_in;
            dst_q  <= dst_in;
            left_q <= words_in;
        end else if (advance) begin
            src_q  <= src_q + WORD_STEP;
            dst_q  <= dst_q + WORD_STEP;
            left_q <= left_q - 1'b1;
        end
    end

    assign sd_addr   = hi_beat ? (src_q + HALF_STEP) : src_q;
    assign ram_addr  = dst_q;
    assign last_word = (left_q == CNT_W'(1));

endmodule

// File: rtl/dma_pack.sv
module dma_pack #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_lo,
    input  logic          cap_hi,
    input  logic [HW-1:0] rdata,
    output logic [2*HW-1:0] wdata
);
    logic [HW-1:0] lo_q;
    logic [HW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= rdata;
            if (cap_hi) hi_q <= rdata;
        end
    end

    assign wdata = {hi_q, lo_q};

endmodule

// File: rtl/dma_elapsed.sv
module dma_elapsed #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int AW           = 32,
    parameter int CNT_W        = 16,
    parameter int ELAPSED_W    = 32,
    parameter int REF_INTERVAL = 936
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CNT_W-1:0]     byte_count,
    input  logic [AW-1:0]        src_addr,
    input  logic [AW-1:0]        dst_addr,
    output logic [2:0]           sd_cmd,
    output logic [AW-1:0]        sd_addr,
    input  logic [15:0]          sd_rdata,
    output logic                 ram_we,
    output logic [AW-1:0]        ram_addr,
    output logic [31:0]          ram_wdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [ELAPSED_W-1:0] elapsed
);
    localparam logic [PH_W-1:0] OPEN_LAST  = PH_W'(OPEN_CYC - 1);
    localparam logic [PH_W-1:0] OPEN_RD    = PH_W'(RCD_CYC);
    localparam logic [PH_W-1:0] PRE_LAST   = PH_W'(PRE_CYC - 1);
    localparam logic [PH_W-1:0] REF_LAST   = PH_W'(REF_CYC - 1);
    localparam logic [PH_W-1:0] REF_ACT    = PH_W'(REF_CYC - 2);
    localparam logic [PH_W-1:0] CLOSE_LAST = PH_W'(CLOSE_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [PH_W-1:0]  phase_q, phase_d;
    logic             err_q, done_q;
    logic             len_ok, accept, reject;
    logic             last_word, ref_pending, ref_service;
    logic [CNT_W-1:0] words_in;
    sd_cmd_e          cmd;

    assign len_ok   = (byte_count != '0) && (byte_count[1:0] == 2'b00);
    assign accept   = (state_q == ST_IDLE) && start && len_ok;
    assign reject   = (state_q == ST_IDLE) && start && !len_ok;
    assign words_in = byte_count >> 2;

    assign ref_service = (state_q == ST_WRITE) && !last_word && ref_pending;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            if (reject) err_q <= 1'b1;
            else if (accept) err_q <= 1'b0;
            done_q <= (state_q == ST_CLOSE) && (phase_q == CLOSE_LAST);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_OPEN;
                    phase_d = '0;
                end
            end
            ST_OPEN: begin
                if (phase_q == OPEN_LAST) begin
                    state_d = ST_BEAT_LO;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            ST_BEAT_LO: state_d = ST_BEAT_HI;
            ST_BEAT_HI: state_d = ST_WRITE;
            ST_WRITE: begin
                phase_d = '0;
                if (last_word)        state_d = ST_CLOSE;
                else if (ref_pending) state_d = ST_PRECH;
                else                  state_d = ST_BEAT_LO;
            end
            ST_PRECH: begin
                if (phase_q == PRE_LAST) begin
                    state_d = ST_REFRESH;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            ST_REFRESH: begin
                if (phase_q == REF_LAST) begin
                    state_d = ST_BEAT_LO;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            ST_CLOSE: begin
                if (phase_q == CLOSE_LAST) begin
                    state_d = ST_IDLE;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                phase_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cmd = CMD_NOP;
        unique case (state_q)
            ST_OPEN: begin
                if (phase_q == '0)          cmd = CMD_ACT;
                else if (phase_q == OPEN_RD) cmd = CMD_READ;
            end
            ST_PRECH: begin
                if (phase_q == '0) cmd = CMD_PRE;
            end
            ST_REFRESH: begin
                if (phase_q == '0)           cmd = CMD_REF;
                else if (phase_q == REF_ACT)  cmd = CMD_ACT;
                else if (phase_q == REF_LAST) cmd = CMD_READ;
            end
            ST_CLOSE: begin
                cmd = (phase_q == '0) ? CMD_BST : CMD_PRE;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign sd_cmd = cmd;
    assign ram_we = (state_q == ST_WRITE);
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign err    = err_q;

    dma_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy),
        .service (ref_service),
        .pending (ref_pending)
    );

    dma_addr_gen #(
        .AW    (AW),
        .CNT_W (CNT_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .src_in    (src_addr),
        .dst_in    (dst_addr),
        .words_in  (words_in),
        .advance   (ram_we),
        .hi_beat   (state_q == ST_BEAT_HI),
        .sd_addr   (sd_addr),
        .ram_addr  (ram_addr),
        .last_word (last_word)
    );

    dma_pack #(
        .HW (16)
    ) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_lo (state_q == ST_BEAT_LO),
        .cap_hi (state_q == ST_BEAT_HI),
        .rdata  (sd_rdata),
        .wdata  (ram_wdata)
    );

    dma_elapsed #(
        .W (ELAPSED_W)
    ) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (busy),
        .count (elapsed)
    );

endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
    parameter int CNT_W     = 16,
    parameter int ELAPSED_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [CNT_W-1:0]     byte_count,
    input logic [2:0]           sd_cmd,
    input logic                 ram_we,
    input logic                 busy,
    input logic                 done,
    input logic                 err,
    input logic [ELAPSED_W-1:0] elapsed
);
    logic bad_len;
    assign bad_len = (byte_count == '0) || (byte_count[1:0] != 2'b00);

    AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sd_cmd == 3'd0); // R1
    AST_REJECT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && bad_len) |=> (err && !busy)); // R2
    AST_ACCEPT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !bad_len) |=> (busy && !err && elapsed == '0)); // R2
    AST_WE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we); // R4
    AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R6
    AST_ELAPSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(elapsed)); // R9

endmodule

bind dma_burst_seq dma_burst_seq_chk #(
    .CNT_W     (CNT_W),
    .ELAPSED_W (ELAPSED_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_count (byte_count),
    .sd_cmd     (sd_cmd),
    .ram_we     (ram_we),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .elapsed    (elapsed)
);

// File: tb/dma_burst_seq_tb.sv
module dma_burst_seq_tb;

    localparam int REF_I = 936;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] byte_count = '0;
    logic [31:0] src_addr = '0;
    logic [31:0] dst_addr = '0;
    logic [2:0]  sd_cmd;
    logic [31:0] sd_addr;
    logic [15:0] sd_rdata;
    logic        ram_we;
    logic [31:0] ram_addr;
    logic [31:0] ram_wdata;
    logic        busy, done, err;
    logic [31:0] elapsed;

    int nvec  = 0;
    int nfail = 0;
    int exp_total = 0;

    typedef struct {
        logic [2:0]  cmd;
        bit          we;
        bit          chk_sa;
        logic [31:0] sa;
        logic [31:0] ra;
        logic [31:0] wd;
        string       tag;
        string       sa_tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    function automatic logic [15:0] sdv(input logic [31:0] a);
        return a[16:1] ^ 16'h5A3C ^ {a[24:17], 8'h00};
    endfunction

    assign sd_rdata = sdv(sd_addr);

    dma_burst_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .byte_count (byte_count),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .sd_cmd     (sd_cmd),
        .sd_addr    (sd_addr),
        .sd_rdata   (sd_rdata),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .elapsed    (elapsed)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t blank();
        exp_t e;
        e.cmd = 3'd0; e.we = 1'b0; e.chk_sa = 1'b0;
        e.sa = '0; e.ra = '0; e.wd = '0; e.tag = "R3"; e.sa_tag = "R5";
        return e;
    endfunction

    task automatic push_cyc(input exp_t e, inout int k, inout int nd, inout bit pend);
        q.push_back(e);
        k++;
        if (k == nd) begin
            pend = 1'b1;
            nd += REF_I;
        end
    endtask

    task automatic build_trace(input int words, input logic [31:0] src, input logic [31:0] dst);
        int   k = 0;
        int   nd = REF_I;
        bit   pend = 1'b0;
        bit   take;
        exp_t e;
        logic [2:0] refcmd [7] = '{3'd4, 3'd0, 3'd5, 3'd0, 3'd0, 3'd1, 3'd2};
        q.delete();
        for (int p = 0; p < 5; p++) begin
            e = blank();
            e.cmd = (p == 0) ? 3'd1 : ((p == 2) ? 3'd2 : 3'd0);
            e.tag = "R3";
            push_cyc(e, k, nd, pend);
        end
        for (int j = 0; j < words; j++) begin
            e = blank(); e.tag = "R4"; e.chk_sa = 1'b1; e.sa = src + 32'(4 * j);
            push_cyc(e, k, nd, pend);
            e = blank(); e.tag = "R4"; e.chk_sa = 1'b1; e.sa = src + 32'(4 * j + 2);
            push_cyc(e, k, nd, pend);
            take = pend && (j != words - 1);
            if (take) pend = 1'b0;
            e = blank(); e.tag = "R4"; e.we = 1'b1; e.ra = dst + 32'(4 * j);
            e.wd = {sdv(src + 32'(4 * j + 2)), sdv(src + 32'(4 * j))};
            push_cyc(e, k, nd, pend);
            if (take) begin
                for (int r = 0; r < 7; r++) begin
                    e = blank(); e.tag = "R7"; e.cmd = refcmd[r];
                    if (r == 6) begin
                        e.chk_sa = 1'b1; e.sa_tag = "R7"; e.sa = src + 32'(4 * (j + 1));
                    end
                    push_cyc(e, k, nd, pend);
                end
            end
        end
        e = blank(); e.tag = "R6"; e.cmd = 3'd3;
        push_cyc(e, k, nd, pend);
        e = blank(); e.tag = "R6"; e.cmd = 3'd4;
        push_cyc(e, k, nd, pend);
        exp_total = k;
    endtask

    task automatic run_xfer(input int bytes, input logic [31:0] src,
                            input logic [31:0] dst, input int mid);
        exp_t e;
        @(negedge clk);
        byte_count = 16'(bytes);
        src_addr = src;
        dst_addr = dst;
        start = 1'b1;
        build_trace(bytes / 4, src, dst);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            e = q[i];
            check(busy === 1'b1, "R6", "busy", 64'(busy), 1);
            check(sd_cmd === e.cmd, e.tag, "sd_cmd", 64'(sd_cmd), 64'(e.cmd));
            check(ram_we === e.we, "R4", "ram_we", 64'(ram_we), 64'(e.we));
            if (e.we) begin
                check(ram_addr === e.ra, "R5", "ram_addr", 64'(ram_addr), 64'(e.ra));
                check(ram_wdata === e.wd, "R4", "ram_wdata", 64'(ram_wdata), 64'(e.wd));
            end
            if (e.chk_sa)
                check(sd_addr === e.sa, e.sa_tag, "sd_addr", 64'(sd_addr), 64'(e.sa));
            check(elapsed === 32'(i), "R9", "elapsed", 64'(elapsed), 64'(i));
            if (i == 0) check(err === 1'b0, "R2", "err cleared", 64'(err), 0);
            if (i == mid) begin
                start = 1'b1;       // R10: must be ignored
                byte_count = 16'd6;
            end else begin
                start = 1'b0;
                byte_count = 16'(bytes);
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(done === 1'b1, "R6", "done", 64'(done), 1);
        check(busy === 1'b0, "R6", "busy end", 64'(busy), 0);
        check(elapsed === 32'(exp_total), "R9", "elapsed total", 64'(elapsed), 64'(exp_total));
        check(err === 1'b0, "R10", "err after busy start", 64'(err), 0);
        @(negedge clk);
        check(done === 1'b0, "R6", "done pulse width", 64'(done), 0);
        check(elapsed === 32'(exp_total), "R9", "elapsed frozen", 64'(elapsed), 64'(exp_total));
        check(sd_cmd === 3'd0, "R1", "idle cmd", 64'(sd_cmd), 0);
    endtask

    task automatic reject_len(input int bytes);
        logic [31:0] el0;
        @(negedge clk);
        el0 = elapsed;
        byte_count = 16'(bytes);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err === 1'b1, "R2", "err set", 64'(err), 1);
        check(busy === 1'b0, "R2", "no busy", 64'(busy), 0);
        @(negedge clk);
        check(busy === 1'b0, "R2", "still idle", 64'(busy), 0);
        check(sd_cmd === 3'd0, "R2", "no command", 64'(sd_cmd), 0);
        check(elapsed === el0, "R2", "elapsed kept", 64'(elapsed), 64'(el0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1", "reset busy", 64'(busy), 0);
        check(done === 1'b0, "R1", "reset done", 64'(done), 0);
        check(err === 1'b0, "R1", "reset err", 64'(err), 0);
        check(ram_we === 1'b0, "R1", "reset we", 64'(ram_we), 0);
        check(sd_cmd === 3'd0, "R1", "reset cmd", 64'(sd_cmd), 0);
        check(elapsed === 32'd0, "R1", "reset elapsed", 64'(elapsed), 0);

        reject_len(0);
        reject_len(6);
        run_xfer(512, 32'h0000_1000, 32'h0000_0200, 40);   // 391 states
        run_xfer(4, 32'h0002_0010, 32'h0000_0F00, -1);
        run_xfer(1240, 32'h0001_0000, 32'h0000_4000, -1);  // R8 refresh due in close
        run_xfer(1244, 32'h0001_0000, 32'h0000_4000, -1);  // R8 pending at last write
        run_xfer(1248, 32'h0003_0000, 32'h0000_8000, -1);  // R7 one refresh
        run_xfer(4096, 32'h0004_0000, 32'h0001_0000, 500); // R7 several refreshes

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule